// File: doc/BRIEF.md
# Disk Channel Register Window

This block is the memory-mapped register front end of a two-drive disk channel. A processor-side bus presents an address inside a 4 KiB window, an access size of 1, 2 or 4 bytes, a read/write flag and write data. The block turns each access into a register slot number and checks whether that slot accepts that width. A valid access to the data port, the task-file slots or the status/command slot becomes a single-cycle strobe on an abstract drive-side register port. The front end also holds a 32-bit timing register and a 32-bit interrupt image register. No other state is kept.

The interrupt image mirrors two interrupt lines. Line 0 is the DMA interrupt and line 1 is the disk interrupt. Each line is also passed straight through to its own output pin. Software clears the DMA image bit by writing a 1 to it, and that bit stays clear until the DMA line next changes level. Read data is registered and is marked valid in the cycle after the read strobe. Any read that matches no slot/width pair returns all ones.

Top module: `atafe_frontend`

## Requirements
- R1: The slot number is the byte address shifted right by 4, so every register fills a 16-byte slot in a 12-bit (4 KiB) address window. Address bits 3:0 do not affect which register is selected.
- R2: Slot 0 is the data port. It accepts only 2-byte and 4-byte accesses, which drive the drive port with `drv_sel` = 0 and with `drv_wide` = 1 for a 4-byte access. A 2-byte read returns drive bits 15:0 zero-extended. A 2-byte write forwards `bus_wdata[15:0]` zero-extended, in little-endian byte order.
- R3: Slots 1 to 7 are task-file registers that accept only 1-byte accesses. They drive `drv_sel` = 1 with `drv_tf_idx` equal to the slot number. A read returns drive bits 7:0 zero-extended, and a write forwards `bus_wdata[7:0]`.
- R4: Slots 0x08 and 0x16 both select the control register with a 1-byte access (`drv_sel` = 2, `drv_tf_idx` = 0). A read fetches drive status and a write issues a drive command with `bus_wdata[7:0]`.
- R5: Slot 0x20 is a 32-bit timing register that is read and written only with 4-byte accesses. A write of any other size leaves it unchanged.
- R6: Slot 0x30 is the interrupt image, read with 4-byte accesses. Bit 31 holds the DMA line and bit 30 holds the disk line. A 4-byte write with bit 31 set clears bit 31, and all other written bits are ignored.
- R7: When an interrupt line changes level, its image bit (31 for line 0, 30 for line 1) takes the new level on the next clock edge. A level change takes priority over a clear in the same cycle.
- R8: A read that matches no valid slot/width pair returns 0xFFFFFFFF. A write that matches none changes no register and raises no drive strobe. Size codes other than 1, 2 or 4 are never valid.
- R9: `bus_rdata` and `bus_rvalid` are registered. `bus_rvalid` is high exactly in the cycle after a read strobe.
- R10: `irq_dma_out` follows the DMA line and `irq_disk_out` follows the disk line.
- R11: Reset clears the timing register, the interrupt image and `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, little-endian, value in the low bytes |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| drv_rd | output | 1 | Drive-side read strobe |
| drv_wr | output | 1 | Drive-side write strobe |
| drv_sel | output | 2 | Drive register group: 0 data, 1 task file, 2 status/command |
| drv_tf_idx | output | 3 | Task-file register number (0 outside the task file) |
| drv_wide | output | 1 | Data-port access is 4 bytes wide |
| drv_wdata | output | 32 | Write data trimmed to the access size |
| drv_rdata | input | 32 | Drive-side read value, same cycle as `drv_rd` |
| irq_dma_lvl | input | 1 | DMA interrupt line (line 0) |
| irq_disk_lvl | input | 1 | Disk interrupt line (line 1) |
| irq_dma_out | output | 1 | DMA interrupt output |
| irq_disk_out | output | 1 | Disk interrupt output |

## Verification
The bench builds the block with its default parameters: a 12-bit window, 16-byte slots and two interrupt lines. With these settings every slot the decoder knows can be reached, including the far alias at 0x16 and the image at 0x30. Addresses with nonzero low nibbles exercise the slot rule. The two lines let the bench test the DMA clear-by-one on its own while the disk bit stays set. They also show that a line that toggles after a clear sets the bit again.

// File: rtl/atafe_pkg.sv
package atafe_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_TASK = 2'd1,
    SEL_CTRL = 2'd2
  } drv_sel_e;

  typedef struct packed {
    logic data;
    logic task_f;
    logic ctrl;
    logic timing;
    logic irq;
  } hit_t;

  // Keep only the bytes an access of the given size carries (little-endian).
  function automatic logic [31:0] trim_to_size(input logic [31:0] v,
                                                input logic [2:0] sz);
    case (sz)
      3'd1:    trim_to_size = {24'h0, v[7:0]};
      3'd2:    trim_to_size = {16'h0, v[15:0]};
      default: trim_to_size = v;
    endcase
  endfunction

endpackage

// File: rtl/atafe_decode.sv
module atafe_decode
  import atafe_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SLOT_SHIFT = 4,
  parameter int IDX_DATA   = 'h00,
  parameter int IDX_TF_LO  = 'h01,
  parameter int IDX_TF_HI  = 'h07,
  parameter int IDX_CTRL_A = 'h08,
  parameter int IDX_CTRL_B = 'h16,
  parameter int IDX_TIMING = 'h20,
  parameter int IDX_IRQ    = 'h30,
  localparam int IDX_W     = ADDR_W - SLOT_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic [IDX_W-1:0]  slot,
  output hit_t              hit,
  output logic              miss
);
  logic sz1, sz2, sz4;

  assign slot = addr[ADDR_W-1:SLOT_SHIFT];
  assign sz1  = (size == 3'd1);
  assign sz2  = (size == 3'd2);
  assign sz4  = (size == 3'd4);

  always_comb begin
    hit.data   = (slot == IDX_W'(IDX_DATA)) && (sz2 || sz4);
    hit.task_f = (slot >= IDX_W'(IDX_TF_LO)) && (slot <= IDX_W'(IDX_TF_HI)) && sz1;
    hit.ctrl   = ((slot == IDX_W'(IDX_CTRL_A)) || (slot == IDX_W'(IDX_CTRL_B))) && sz1;
    hit.timing = (slot == IDX_W'(IDX_TIMING)) && sz4;
    hit.irq    = (slot == IDX_W'(IDX_IRQ)) && sz4;
  end

  assign miss = ~|hit;
endmodule

// File: rtl/atafe_irq_image.sv
module atafe_irq_image #(
  parameter int NUM_LINES = 2,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic                 clr_top,
  output logic [NUM_LINES-1:0] line_q,
  output logic [NUM_LINES-1:0] line_evt,
  output logic [DATA_W-1:0]    image
);
  logic [NUM_LINES-1:0] state;

  assign line_evt = lines ^ line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= lines;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    if (n == 0) begin : g_clearable
      always_ff @(posedge clk) begin
        if (!rst_n)           state[n] <= 1'b0;
        else if (line_evt[n]) state[n] <= lines[n];
        else if (clr_top)     state[n] <= 1'b0;
      end
    end else begin : g_mirror
      always_ff @(posedge clk) begin
        if (!rst_n)           state[n] <= 1'b0;
        else if (line_evt[n]) state[n] <= lines[n];
      end
    end
  end

  always_comb begin
    image = '0;
    for (int n = 0; n < NUM_LINES; n++) image[DATA_W-1-n] = state[n];
  end
endmodule

// File: rtl/atafe_frontend.sv
module atafe_frontend
  import atafe_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SLOT_SHIFT = 4,
  parameter int NUM_LINES  = 2,
  localparam int DATA_W    = 32,
  localparam int IDX_W     = ADDR_W - SLOT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              drv_rd,
  output logic              drv_wr,
  output logic [1:0]        drv_sel,
  output logic [2:0]        drv_tf_idx,
  output logic              drv_wide,
  output logic [DATA_W-1:0] drv_wdata,
  input  logic [DATA_W-1:0] drv_rdata,
  input  logic              irq_dma_lvl,
  input  logic              irq_disk_lvl,
  output logic              irq_dma_out,
  output logic              irq_disk_out
);
  hit_t                 hit;
  logic [IDX_W-1:0]     slot;
  logic                 miss;
  logic                 rd_strobe, wr_strobe, fwd;
  logic                 timing_wr, irq_clr;
  logic [DATA_W-1:0]    timing_q;
  logic [DATA_W-1:0]    irq_image;
  logic [NUM_LINES-1:0] lines, line_q, line_evt;
  logic [DATA_W-1:0]    rd_next;

  atafe_decode #(.ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT)) i_decode (
    .addr(bus_addr), .size(bus_size), .slot(slot), .hit(hit), .miss(miss)
  );

  assign rd_strobe = bus_req && !bus_we;
  assign wr_strobe = bus_req && bus_we;
  assign fwd       = hit.data || hit.task_f || hit.ctrl;

  // Drive-side port: strobes in the access cycle.
  assign drv_rd     = rd_strobe && fwd;
  assign drv_wr     = wr_strobe && fwd;
  assign drv_sel    = hit.data ? SEL_DATA : (hit.task_f ? SEL_TASK : SEL_CTRL);
  assign drv_tf_idx = hit.task_f ? slot[2:0] : 3'd0;
  assign drv_wide   = hit.data && (bus_size == 3'd4);
  assign drv_wdata  = trim_to_size(bus_wdata, bus_size);

  // Timing register.
  assign timing_wr = wr_strobe && hit.timing;
  always_ff @(posedge clk) begin
    if (!rst_n)         timing_q <= '0;
    else if (timing_wr) timing_q <= bus_wdata;
  end

  // Interrupt image.
  assign irq_clr = wr_strobe && hit.irq && bus_wdata[DATA_W-1];
  assign lines   = NUM_LINES'({irq_disk_lvl, irq_dma_lvl});

  atafe_irq_image #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) i_irq (
    .clk(clk), .rst_n(rst_n), .lines(lines), .clr_top(irq_clr),
    .line_q(line_q), .line_evt(line_evt), .image(irq_image)
  );

  assign irq_dma_out  = irq_dma_lvl;
  assign irq_disk_out = irq_disk_lvl;

  // Registered read path.
  always_comb begin
    if (hit.data || hit.task_f || hit.ctrl) rd_next = trim_to_size(drv_rdata, bus_size);
    else if (hit.timing)                    rd_next = timing_q;
    else if (hit.irq)                       rd_next = irq_image;
    else                                    rd_next = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_strobe;
      if (rd_strobe) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/atafe_checker.sv
module atafe_checker #(
  parameter int NUM_LINES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 bus_rvalid,
  input logic                 drv_rd,
  input logic                 drv_wr,
  input logic                 miss,
  input logic                 timing_wr,
  input logic [31:0]          timing_q,
  input logic                 irq_clr,
  input logic [31:0]          irq_image,
  input logic [NUM_LINES-1:0] lines,
  input logic [NUM_LINES-1:0] line_evt
);
  // R8: a missed read answers all ones
  a_r8_miss_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && miss) |=> (bus_rdata == 32'hFFFF_FFFF));

  // R8: a missed access never reaches the drive
  a_r8_miss_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && miss) |-> (!drv_rd && !drv_wr));

  // R9: valid exactly one cycle after a read strobe
  a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);
  a_r9_rvalid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  // R5: timing register loads on its write and holds otherwise
  a_r5_timing_load: assert property (@(posedge clk) disable iff (!rst_n)
    timing_wr |=> (timing_q == $past(bus_wdata)));
  a_r5_timing_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !timing_wr |=> $stable(timing_q));

  // R6: a clear with no line change drops bit 31
  a_r6_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !line_evt[0]) |=> !irq_image[31]);

  // R7: a line change lands in its image bit
  a_r7_dma_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt[0] |=> (irq_image[31] == $past(lines[0])));
  a_r7_disk_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt[1] |=> (irq_image[30] == $past(lines[1])));

  // R2: never a read and a write strobe together
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_rd && drv_wr));
endmodule

bind atafe_frontend atafe_checker #(.NUM_LINES(NUM_LINES)) i_checker (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .drv_rd(drv_rd), .drv_wr(drv_wr), .miss(miss), .timing_wr(timing_wr),
  .timing_q(timing_q), .irq_clr(irq_clr), .irq_image(irq_image),
  .lines(lines), .line_evt(line_evt)
);

// File: tb/test_atafe_frontend.sv
module test_atafe_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [2:0]  bus_size = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        drv_rd, drv_wr, drv_wide;
  logic [1:0]  drv_sel;
  logic [2:0]  drv_tf_idx;
  logic [31:0] drv_wdata, drv_rdata;
  logic        irq_dma_lvl = 1'b0, irq_disk_lvl = 1'b0;
  logic        irq_dma_out, irq_disk_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Drive model: value encodes the group and register it was asked for.
  assign drv_rdata = {16'hBEEF, 8'hA5, 1'b0, drv_sel, 2'b00, drv_tf_idx};

  atafe_frontend i_atafe_frontend (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .drv_rd(drv_rd),
    .drv_wr(drv_wr), .drv_sel(drv_sel), .drv_tf_idx(drv_tf_idx),
    .drv_wide(drv_wide), .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .irq_dma_lvl(irq_dma_lvl), .irq_disk_lvl(irq_disk_lvl),
    .irq_dma_out(irq_dma_out), .irq_disk_out(irq_disk_out)
  );

  // Capture of drive-side writes.
  int          wr_cnt = 0;
  logic [1:0]  cap_sel;
  logic [2:0]  cap_idx;
  logic [31:0] cap_wdata;
  logic        cap_wide;
  always @(posedge clk) begin
    if (drv_wr) begin
      wr_cnt    <= wr_cnt + 1;
      cap_sel   <= drv_sel;
      cap_idx   <= drv_tf_idx;
      cap_wdata <= drv_wdata;
      cap_wide  <= drv_wide;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] sz,
                        input logic [11:0] a, input logic [31:0] wd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // {we, size, addr, wdata, expected read}
  localparam int NV = 15;
  localparam logic [79:0] VEC [NV] = '{
    {1'b0, 3'd4, 12'h000, 32'h0, 32'hBEEFA500},  // R2 4-byte data
    {1'b0, 3'd2, 12'h004, 32'h0, 32'h0000A500},  // R2 R1 2-byte data, low nibble set
    {1'b0, 3'd1, 12'h000, 32'h0, 32'hFFFFFFFF},  // R8 byte on data port
    {1'b0, 3'd1, 12'h03A, 32'h0, 32'h00000023},  // R3 task reg 3
    {1'b0, 3'd1, 12'h07F, 32'h0, 32'h00000027},  // R3 task reg 7
    {1'b0, 3'd2, 12'h070, 32'h0, 32'hFFFFFFFF},  // R8 wide task access
    {1'b0, 3'd1, 12'h080, 32'h0, 32'h00000040},  // R4 status at 0x08
    {1'b0, 3'd1, 12'h165, 32'h0, 32'h00000040},  // R4 status alias 0x16
    {1'b1, 3'd4, 12'h200, 32'hCAFEF00D, 32'h0},  // R5 timing write
    {1'b0, 3'd4, 12'h20C, 32'h0, 32'hCAFEF00D},  // R5 R1 timing read
    {1'b1, 3'd2, 12'h200, 32'h11111111, 32'h0},  // R5 narrow write ignored
    {1'b0, 3'd4, 12'h200, 32'h0, 32'hCAFEF00D},  // R5 still held
    {1'b0, 3'd2, 12'h200, 32'h0, 32'hFFFFFFFF},  // R8 narrow timing read
    {1'b0, 3'd4, 12'h0F0, 32'h0, 32'hFFFFFFFF},  // R8 unmapped slot
    {1'b0, 3'd3, 12'h000, 32'h0, 32'hFFFFFFFF}   // R8 bad size code
  };

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    chk("R11 rvalid in reset", {31'h0, bus_rvalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 3'd4, 12'h200, 0);
    chk("R11 timing reset", bus_rdata, 32'h0);
    chk("R9 rvalid after read", {31'h0, bus_rvalid}, 32'h1);
    access(1'b0, 3'd4, 12'h300, 0);
    chk("R11 irq image reset", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][79], VEC[i][78:76], VEC[i][75:64], VEC[i][63:32]);
      if (!VEC[i][79]) chk($sformatf("R1/R2/R3/R4/R5/R8 vector %0d", i), bus_rdata, VEC[i][31:0]);
    end

    // Drive-side writes
    w0 = wr_cnt;
    access(1'b1, 3'd1, 12'h050, 32'hAABBCC5E);
    chk("R3 task write count", wr_cnt - w0, 1);
    chk("R3 task write sel", {30'h0, cap_sel}, 32'd1);
    chk("R3 task write idx", {29'h0, cap_idx}, 32'd5);
    chk("R3 task write data", cap_wdata, 32'h5E);
    chk("R9 no rvalid after write", {31'h0, bus_rvalid}, 32'h0);
    access(1'b1, 3'd1, 12'h160, 32'h123456EC);
    chk("R4 command sel", {30'h0, cap_sel}, 32'd2);
    chk("R4 command data", cap_wdata, 32'hEC);
    access(1'b1, 3'd2, 12'h000, 32'h12345678);
    chk("R2 half write data", cap_wdata, 32'h5678);
    chk("R2 half write narrow", {31'h0, cap_wide}, 32'h0);
    access(1'b1, 3'd4, 12'h008, 32'h12345678);
    chk("R2 word write data", cap_wdata, 32'h12345678);
    chk("R2 word write wide", {31'h0, cap_wide}, 32'h1);
    w0 = wr_cnt;
    access(1'b1, 3'd1, 12'h000, 32'hFF);
    access(1'b1, 3'd4, 12'h050, 32'hFF);
    chk("R8 invalid writes no strobe", wr_cnt - w0, 0);

    // Interrupt image
    @(negedge clk); irq_dma_lvl = 1'b1;
    @(negedge clk);
    chk("R10 dma out", {31'h0, irq_dma_out}, 32'h1);
    access(1'b0, 3'd4, 12'h300, 0);
    chk("R7 dma bit set", bus_rdata, 32'h80000000);
    @(negedge clk); irq_disk_lvl = 1'b1;
    @(negedge clk);
    chk("R10 disk out", {31'h0, irq_disk_out}, 32'h1);
    access(1'b0, 3'd4, 12'h304, 0);
    chk("R7 both bits set", bus_rdata, 32'hC0000000);
    access(1'b1, 3'd4, 12'h300, 32'h40000000);
    access(1'b0, 3'd4, 12'h300, 0);
    chk("R6 bit30 write ignored", bus_rdata, 32'hC0000000);
    access(1'b1, 3'd2, 12'h300, 32'h80000000);
    access(1'b0, 3'd4, 12'h300, 0);
    chk("R6 narrow clear ignored", bus_rdata, 32'hC0000000);
    access(1'b1, 3'd4, 12'h300, 32'h80000000);
    access(1'b0, 3'd4, 12'h300, 0);
    chk("R6 dma bit cleared, line high", bus_rdata, 32'h40000000);
    @(negedge clk); irq_disk_lvl = 1'b0;
    @(negedge clk);
    access(1'b0, 3'd4, 12'h300, 0);
    chk("R7 disk bit follows low", bus_rdata, 32'h00000000);
    chk("R10 disk out low", {31'h0, irq_disk_out}, 32'h0);
    @(negedge clk); irq_dma_lvl = 1'b0;
    @(negedge clk); irq_dma_lvl = 1'b1;
    @(negedge clk);
    access(1'b0, 3'd4, 12'h300, 0);
    chk("R7 dma re-set after toggle", bus_rdata, 32'h80000000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule